// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial-audio bit clock and the left/right frame clock for a port that drives its own clocks. It runs on the audio master clock and divides it by a ratio chosen with a three-bit multiplier code and a base-rate select. One family of ratios is powers of two (512 down to 32 master cycles per frame). The other is three times a power of two (384 down to 48 master cycles per frame). A frame-width select sets 32 or 48 bit clocks per frame. The master cycles per bit clock are therefore the ratio divided by the bits per frame. A combination that does not give a whole divide of at least two is refused: the block raises a configuration error and keeps its clocks stopped.

Beside the two clocks the block gives single-cycle strobes. One marks the cycle in which the bit clock falls, where a transmitter shifts out its next bit. The other marks the cycle in which it rises, where a receiver samples. The generator runs only while run is high and the clock gate is low. Each time it starts, it begins from a fixed phase: bit clock low, frame clock at the left-channel level (low). It captures the configuration in that same start cycle.

The sequencer has four states. ST_IDLE holds everything low and tracks the live configuration. ST_IDLE goes to ST_LOW on enable with a legal configuration and to ST_FAULT on enable with an illegal one. ST_LOW (bit clock low) goes to ST_HIGH after its low-phase count. ST_HIGH goes back to ST_LOW after its high-phase count, and the frame clock may toggle on that return. Any state goes to ST_IDLE when the enable drops.

Top module: `audio_clkgen`

## Requirements
- R1: With base_rate 0, mult_code values 0, 1, 2, 3, 4 give 512, 256, 128, 64, 32 master cycles per frame; codes 5 to 7 are illegal.
- R2: With base_rate 1, mult_code values 0, 1, 2, 3 give 384, 192, 96, 48 master cycles per frame; codes 4 to 7 are illegal.
- R3: wide_frame 1 gives 48 bit clocks per frame and wide_frame 0 gives 32, so one bit period lasts ratio/bits master cycles.
- R4: In each bit period bclk is low for the first ceil(d/2) cycles and high for the remaining floor(d/2) cycles, where d is the divide; for even d this is a 50% duty cycle.
- R5: fclk is 0 (left) in the first cycle after the enable rises and toggles every half frame (16 or 24 bit periods), always in a cycle where bclk falls.
- R6: shift_stb is high for exactly the one cycle in which bclk falls (the first low cycle of each bit period, including the first cycle after start), and sample_stb is high for exactly the cycle in which bclk rises.
- R7: If the ratio is not a whole multiple of the bits per frame, or the divide is below 2, or the code is outside its table, then cfg_err goes high in the first cycle after the enable rises. It stays high while enabled, bclk, fclk and both strobes stay 0, and cfg_err clears one cycle after the enable falls.
- R8: run low or clk_gate high stops the generator: one cycle later every output is 0. The next start begins again from phase zero.
- R9: Changes to mult_code, base_rate or wide_frame while the generator is running have no effect until the next start.
- R10: During and right after reset, with run low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables clock generation |
| clk_gate | input | 1 | When high, holds the generator stopped |
| mult_code | input | 3 | Ratio multiplier code |
| base_rate | input | 1 | 0: power-of-two ratios, 1: three-times ratios |
| wide_frame | input | 1 | 1: 48 bit clocks per frame, 0: 32 |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Left/right frame clock, 0 for left |
| shift_stb | output | 1 | One-cycle strobe at the bit clock falling edge |
| sample_stb | output | 1 | One-cycle strobe at the bit clock rising edge |
| cfg_err | output | 1 | Illegal ratio and frame-width combination while enabled |

## Verification
The bench builds the block with its default parameters: 32 and 48 bits per frame, and ratio tops of 512 and 384 with smallest ratios of 32 and 48. With these values the whole configuration space is 32 combinations of base, code and width, and the bench sweeps every one. For each legal setting it follows every cycle of two full frames. This covers the odd divide of 3, the smallest divide of 2 and the largest of 16, as well as every illegal case. Stops in mid-frame through the gate, and configuration changes while running, are short enough to check cycle by cycle against an arithmetic model of phase, bit index and half frame.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FAULT = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } gen_state_t;

endpackage

// File: rtl/clkgen_ratio_dec.sv
module clkgen_ratio_dec #(
    parameter int unsigned CODE_W      = 3,
    parameter int unsigned NARROW_BITS = 32,
    parameter int unsigned WIDE_BITS   = 48,
    parameter int unsigned POW2_TOP    = 512,
    parameter int unsigned POW2_MIN    = 32,
    parameter int unsigned TRI_TOP     = 384,
    parameter int unsigned TRI_MIN     = 48,
    parameter int unsigned DIV_W       = 5,
    parameter int unsigned HALF_W      = 5
) (
    input  logic [CODE_W-1:0] mult_code,
    input  logic              base_rate,
    input  logic              wide_frame,
    output logic              legal,
    output logic [DIV_W-1:0]  div,
    output logic [HALF_W-1:0] half_bits
);

    localparam int unsigned POW2_CODES = $clog2(POW2_TOP / POW2_MIN) + 1;
    localparam int unsigned TRI_CODES  = $clog2(TRI_TOP / TRI_MIN) + 1;
    localparam int unsigned DIV_LIMIT  = 2 ** DIV_W;

    int unsigned ratio;
    int unsigned bpf;
    int unsigned quot;
    int unsigned rem;

    always_comb begin
        ratio = 0;
        if (base_rate) begin
            if (32'(mult_code) < TRI_CODES) begin
                ratio = TRI_TOP >> mult_code;
            end
        end else begin
            if (32'(mult_code) < POW2_CODES) begin
                ratio = POW2_TOP >> mult_code;
            end
        end
        if (wide_frame) begin
            bpf  = WIDE_BITS;
            quot = ratio / WIDE_BITS;
            rem  = ratio % WIDE_BITS;
        end else begin
            bpf  = NARROW_BITS;
            quot = ratio / NARROW_BITS;
            rem  = ratio % NARROW_BITS;
        end
        legal     = (ratio != 0) && (rem == 0) && (quot >= 2) && (quot < DIV_LIMIT);
        div       = DIV_W'(quot);
        half_bits = HALF_W'(bpf / 2);
    end

endmodule

// File: rtl/clkgen_seq.sv
module clkgen_seq
    import clkgen_pkg::*;
#(
    parameter int unsigned DIV_W  = 5,
    parameter int unsigned HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              legal,
    input  logic [DIV_W-1:0]  div,
    input  logic [HALF_W-1:0] half_bits,
    output logic              bclk,
    output logic              fclk,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic              cfg_err
);

    gen_state_t        state, state_n;
    logic [DIV_W-1:0]  ph_cnt;
    logic [DIV_W-1:0]  lo_len, hi_len;
    logic [HALF_W-1:0] bit_idx, half_q;
    logic              lo_done, hi_done, half_wrap, fall_evt;

    assign lo_done   = (ph_cnt == DIV_W'(lo_len - 1'b1));
    assign hi_done   = (ph_cnt == DIV_W'(hi_len - 1'b1));
    assign half_wrap = (bit_idx == HALF_W'(half_q - 1'b1));
    assign fall_evt  = (state == ST_HIGH) && (state_n == ST_LOW);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (go) state_n = legal ? ST_LOW : ST_FAULT;
            ST_FAULT: if (!go) state_n = ST_IDLE;
            ST_LOW: begin
                if (!go)          state_n = ST_IDLE;
                else if (lo_done) state_n = ST_HIGH;
            end
            ST_HIGH: begin
                if (!go)          state_n = ST_IDLE;
                else if (hi_done) state_n = ST_LOW;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ph_cnt  <= '0;
            bit_idx <= '0;
            lo_len  <= '0;
            hi_len  <= '0;
            half_q  <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE) begin
                lo_len <= DIV_W'(div - (div >> 1));
                hi_len <= DIV_W'(div >> 1);
                half_q <= half_bits;
            end
            if ((state_n != state) || (state_n == ST_IDLE) || (state_n == ST_FAULT)) begin
                ph_cnt <= '0;
            end else begin
                ph_cnt <= DIV_W'(ph_cnt + 1'b1);
            end
            if ((state_n == ST_IDLE) || (state_n == ST_FAULT)) begin
                bit_idx <= '0;
            end else if (fall_evt) begin
                bit_idx <= half_wrap ? '0 : HALF_W'(bit_idx + 1'b1);
            end
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk       <= 1'b0;
            fclk       <= 1'b0;
            shift_stb  <= 1'b0;
            sample_stb <= 1'b0;
            cfg_err    <= 1'b0;
        end else begin
            bclk       <= (state_n == ST_HIGH);
            shift_stb  <= (state_n == ST_LOW) && (state != ST_LOW);
            sample_stb <= (state_n == ST_HIGH) && (state != ST_HIGH);
            cfg_err    <= (state_n == ST_FAULT);
            if ((state_n == ST_IDLE) || (state_n == ST_FAULT)) begin
                fclk <= 1'b0;
            end else if (fall_evt && half_wrap) begin
                fclk <= ~fclk;
            end
        end
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
    parameter int unsigned CODE_W      = 3,
    parameter int unsigned NARROW_BITS = 32,
    parameter int unsigned WIDE_BITS   = 48,
    parameter int unsigned POW2_TOP    = 512,
    parameter int unsigned POW2_MIN    = 32,
    parameter int unsigned TRI_TOP     = 384,
    parameter int unsigned TRI_MIN     = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clk_gate,
    input  logic [CODE_W-1:0] mult_code,
    input  logic              base_rate,
    input  logic              wide_frame,
    output logic              bclk,
    output logic              fclk,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic              cfg_err
);

    localparam int unsigned TOP_MAX = (POW2_TOP > TRI_TOP) ? POW2_TOP : TRI_TOP;
    localparam int unsigned DIV_W   = $clog2(TOP_MAX / NARROW_BITS + 1);
    localparam int unsigned HALF_W  = $clog2(WIDE_BITS / 2 + 1);

    logic              go;
    logic              legal;
    logic [DIV_W-1:0]  div;
    logic [HALF_W-1:0] half_bits;

    assign go = run && !clk_gate;

    clkgen_ratio_dec #(
        .CODE_W(CODE_W), .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS),
        .POW2_TOP(POW2_TOP), .POW2_MIN(POW2_MIN),
        .TRI_TOP(TRI_TOP), .TRI_MIN(TRI_MIN),
        .DIV_W(DIV_W), .HALF_W(HALF_W)
    ) u_dec (
        .mult_code (mult_code),
        .base_rate (base_rate),
        .wide_frame(wide_frame),
        .legal     (legal),
        .div       (div),
        .half_bits (half_bits)
    );

    clkgen_seq #(
        .DIV_W(DIV_W), .HALF_W(HALF_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .legal     (legal),
        .div       (div),
        .half_bits (half_bits),
        .bclk      (bclk),
        .fclk      (fclk),
        .shift_stb (shift_stb),
        .sample_stb(sample_stb),
        .cfg_err   (cfg_err)
    );

endmodule

// File: rtl/audio_clkgen_checker.sv
module audio_clkgen_checker (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic clk_gate,
    input logic bclk,
    input logic fclk,
    input logic shift_stb,
    input logic sample_stb,
    input logic cfg_err
);

    a_r6_sample_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> bclk);

    a_r6_shift_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> !bclk);

    a_r6_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> sample_stb);

    a_r6_fall_marked: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bclk) && $past(run && !clk_gate)) |-> shift_stb);

    a_r5_frame_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fclk) && $past(run && !clk_gate)) |-> shift_stb);

    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!bclk && !fclk && !shift_stb && !sample_stb));

    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && !clk_gate) |=> (!bclk && !fclk && !shift_stb && !sample_stb && !cfg_err));

endmodule

bind audio_clkgen audio_clkgen_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clk_gate  (clk_gate),
    .bclk      (bclk),
    .fclk      (fclk),
    .shift_stb (shift_stb),
    .sample_stb(sample_stb),
    .cfg_err   (cfg_err)
);

// File: tb/test_audio_clkgen.sv
`timescale 1ns/1ps
module test_audio_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       clk_gate = 1'b0;
    logic [2:0] mult_code = 3'd0;
    logic       base_rate = 1'b0;
    logic       wide_frame = 1'b0;
    logic       bclk, fclk, shift_stb, sample_stb, cfg_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    audio_clkgen i_audio_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .clk_gate(clk_gate),
        .mult_code(mult_code), .base_rate(base_rate), .wide_frame(wide_frame),
        .bclk(bclk), .fclk(fclk), .shift_stb(shift_stb),
        .sample_stb(sample_stb), .cfg_err(cfg_err)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    // order of the vector: bclk fclk shift sample err
    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic b, input logic [2:0] c);
        if (b) return (c <= 3) ? (384 >> c) : 0;
        return (c <= 4) ? (512 >> c) : 0;
    endfunction

    function automatic logic [4:0] expect_at(input int ratio, input int bpf, input int t);
        int d, lo, ph, bitg;
        if (ratio == 0 || (ratio % bpf) != 0 || (ratio / bpf) < 2) return 5'b00001;
        d    = ratio / bpf;
        lo   = d - d / 2;
        ph   = t % d;
        bitg = t / d;
        return {ph >= lo, ((bitg / (bpf / 2)) % 2) == 1, ph == 0, ph == lo, 1'b0};
    endfunction

    function automatic logic [4:0] got();
        return {bclk, fclk, shift_stb, sample_stb, cfg_err};
    endfunction

    // called at a negedge with run low; starts and follows ncyc cycles
    task automatic run_cfg(input logic b, input logic [2:0] c, input logic w,
                           input int ncyc, input string tag);
        int ratio, bpf;
        ratio = ratio_of(b, c);
        bpf   = w ? 48 : 32;
        base_rate = b; mult_code = c; wide_frame = w;
        run = 1'b1;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            check(tag, got(), expect_at(ratio, bpf, t));
        end
        run = 1'b0;
        @(negedge clk);
        check("R8 R7 stop", got(), 5'b00000);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 in reset", got(), 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", got(), 5'b00000);

        // R1 R2 R3 R4 R5 R6 R7: full sweep of the configuration space
        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 8; c++) begin
                for (int w = 0; w < 2; w++) begin
                    int r;
                    r = ratio_of(b[0], c[2:0]);
                    run_cfg(b[0], c[2:0], w[0], (r == 0) ? 8 : 2 * r + 6,
                            b == 0 ? "R1 R3 R4 R5 R6 R7" : "R2 R3 R4 R5 R6 R7");
                end
            end
        end

        // R8: gate in mid-frame then restart from phase zero
        base_rate = 1'b0; mult_code = 3'd3; wide_frame = 1'b0; run = 1'b1;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            check("R8 before gate", got(), expect_at(64, 32, t));
        end
        clk_gate = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 gated", got(), 5'b00000);
        end
        clk_gate = 1'b0;
        for (int t = 0; t < 80; t++) begin
            @(negedge clk);
            check("R8 restart", got(), expect_at(64, 32, t));
        end
        run = 1'b0;
        @(negedge clk);

        // R9: configuration changes while running are ignored
        base_rate = 1'b1; mult_code = 3'd1; wide_frame = 1'b0; run = 1'b1;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            check("R9 hold config", got(), expect_at(192, 32, t));
            if (t == 20) begin base_rate = 1'b0; mult_code = 3'd4; end
            if (t == 100) begin wide_frame = 1'b1; mult_code = 3'd7; end
        end
        run = 1'b0;
        @(negedge clk);
        check("R9 stop", got(), 5'b00000);

        summary();
    end

endmodule